// File: doc/BRIEF.md
# Prioritised Latching Interrupt Controller

This controller takes single-cycle event pulses from six sources: a short-period timer tick, a long-period timer tick, two USB endpoints, a general-purpose pin group and an external wake pin. Each pulse sets a sticky pending flag for its source. A global enable register, which the CPU reads and writes through a small I/O port, gates the pending flags. When at least one enabled flag is pending, the controller raises an interrupt request and presents the index of the most urgent source.

The CPU acknowledges at an instruction boundary. On that cycle the controller performs the whole service step by itself. It wipes the entire enable register, so every source is masked. It also drops the pending flag of the source it presented. The presented index serves as the call vector. A handler that wants nesting must write the enable bits again. Events that arrive while their source is masked stay pending and are served once the source is unmasked.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, no flag is pending and `irq_o` is low.
- R2: A write with `io_addr` equal to 0x20 loads the enable register, and a read at 0x20 returns it. A write at any other address changes nothing, and a read at any other address returns 0x00.
- R3: Register bits 0 and 5 ignore writes and always read 0. Bits 1, 2, 3, 4, 6 and 7 enable sources 0 through 5 respectively.
- R4: A pulse on `evt_i[k]` sets pending flag k whatever its enable bit is. The flag stays set until source k is serviced or reset occurs.
- R5: `irq_o` is high in the same cycle, combinationally, exactly when some source is both pending and enabled.
- R6: While `irq_o` is high, `vec_o` holds the lowest index among the pending and enabled sources. Index 0 is the short timer tick, then the long tick, endpoint 0, endpoint 1, the pin group and the wake pin, up to index 5.
- R7: `ack_i` high while `irq_o` is high clears the whole enable register. It also clears the pending flag of the source `vec_o` names. Other pending flags are kept.
- R8: `ack_i` while `irq_o` is low has no effect.
- R9: If `evt_i[k]` is high in the same cycle that source k is serviced, flag k stays set.
- R10: If a register write and a taken acknowledge fall in the same cycle, the register ends up 0x00.
- R11: After a service, software can write the enable bits again, and a further pending source is then requested and can be serviced in turn (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses, index = priority position |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| ack_i | input | 1 | Instruction-boundary acknowledge |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 3 | Index of the source to be serviced |

## Verification
Two pairs of actions can land in the same cycle. In the first, a new event for a source arrives while that source's flag is being cleared by an acknowledge. In the second, a software write to the enable register coincides with a taken acknowledge. The bench drives each pair in one cycle on purpose. After the first, it re-enables every source and expects the same source to be requested again. After the second, it reads the register and expects zero. A sweep over all pending and enable patterns also services one source. It then unmasks every source and checks the request and vector that remain against arithmetic on the pattern.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int          AW      = 8,
  parameter logic [7:0]  EN_ADDR = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    evt_i,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          ack_i,
  output logic          irq_o,
  output logic [2:0]    vec_o
);
  localparam int         NSRC = 6;
  localparam int         VW   = 3;
  localparam logic [7:0] RSV  = 8'b0010_0001;

  logic [7:0]      en_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] en_src;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] clr;
  logic            sel;
  logic            take;

  assign en_src = {en_q[7], en_q[6], en_q[4], en_q[3], en_q[2], en_q[1]};
  assign req    = pend_q & en_src;
  assign irq_o  = |req;
  assign sel    = (io_addr == AW'(EN_ADDR));
  assign take   = ack_i & irq_o;
  assign io_rdata = sel ? en_q : 8'h00;

  always_comb begin
    vec_o = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) vec_o = VW'(i);
  end

  always_comb begin
    clr = '0;
    if (take) clr[vec_o] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            en_q <= 8'h00;
    else if (take)         en_q <= 8'h00;
    else if (io_wr && sel) en_q <= io_wdata & ~RSV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | evt_i;
  end
endmodule

module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] evt_i,
  input logic       io_wr,
  input logic [7:0] io_rdata,
  input logic       ack_i,
  input logic       irq_o,
  input logic [2:0] vec_o,
  input logic [7:0] en_q,
  input logic [5:0] pend_q
);
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata[0] == 1'b0) && (io_rdata[5] == 1'b0));

  assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_i && irq_o) |=> (($past(pend_q) & ~pend_q) == 6'd0));

  assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o < 3'd6));

  assert_ack_wipes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (en_q == 8'h00));

  assert_idle_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !io_wr) |=> $stable(en_q));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && evt_i[vec_o]) |=> pend_q[$past(vec_o)]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .io_wr(io_wr), .io_rdata(io_rdata),
  .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o), .en_q(en_q), .pend_q(pend_q)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt_i = '0;
  logic [7:0] io_addr = 8'h20;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] to_reg(input logic [5:0] m);
    return {m[5], m[4], 1'b0, m[3], m[2], m[1], m[0], 1'b0};
  endfunction

  function automatic int lowest(input logic [5:0] v);
    for (int i = 5; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = 0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1; cyc(); io_wr = 1'b0; io_addr = 8'h20;
  endtask

  task automatic pulse(input logic [5:0] p);
    evt_i = p; cyc(); evt_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R1 reg", io_rdata, 0);
    chk("R1 irq", irq_o, 0);
    wr(8'h20, 8'hDE); pulse(6'h3F); #1;
    chk("R1 no stale pending, all enabled -> vec", vec_o, 0);

    do_reset();
    wr(8'h21, 8'hFF);
    io_addr = 8'h21; #1;
    chk("R2 other addr read", io_rdata, 0);
    io_addr = 8'h20; #1;
    chk("R2 other addr write ignored", io_rdata, 0);
    wr(8'h20, 8'hFF); #1;
    chk("R3 reserved bits", io_rdata, 8'hDE);
    wr(8'h20, 8'h00); #1;
    chk("R2 write zero", io_rdata, 0);

    do_reset();
    pulse(6'b001000); #1;
    chk("R4 disabled no irq", irq_o, 0);
    repeat (3) cyc();
    wr(8'h20, to_reg(6'b001000)); #1;
    chk("R4 held then irq", irq_o, 1);
    chk("R6 vec", vec_o, 3);

    wr(8'h20, 8'h00);
    pulse(6'b000001);
    wr(8'h20, to_reg(6'b000001));
    ack(); #1;
    chk("R7 reg wiped", io_rdata, 0);
    wr(8'h20, to_reg(6'b001001)); #1;
    chk("R7 other kept vec", vec_o, 3);

    do_reset();
    wr(8'h20, 8'h82); #1;
    ack(); #1;
    chk("R8 idle ack reg", io_rdata, 8'h82);
    chk("R8 idle ack irq", irq_o, 0);

    do_reset();
    pulse(6'b000100);
    wr(8'h20, to_reg(6'b000100));
    evt_i = 6'b000100; ack_i = 1'b1; cyc(); evt_i = '0; ack_i = 1'b0; #1;
    chk("R9 reg wiped", io_rdata, 0);
    wr(8'h20, 8'hDE); #1;
    chk("R9 set wins irq", irq_o, 1);
    chk("R9 set wins vec", vec_o, 2);

    do_reset();
    pulse(6'b000010);
    wr(8'h20, to_reg(6'b000010));
    io_wr = 1'b1; io_wdata = 8'hFF; ack_i = 1'b1; cyc(); io_wr = 1'b0; ack_i = 1'b0; #1;
    chk("R10 ack beats write", io_rdata, 0);

    do_reset();
    pulse(6'b100001);
    wr(8'h20, 8'hDE); #1;
    chk("R11 first vec", vec_o, 0);
    ack();
    wr(8'h20, to_reg(6'b100000)); #1;
    chk("R11 nested irq", irq_o, 1);
    chk("R11 nested vec", vec_o, 5);
    ack(); #1;
    chk("R11 nested done", irq_o, 0);
    wr(8'h20, 8'hDE); #1;
    chk("R11 all served", irq_o, 0);

    for (int p = 0; p < 64; p++) begin
      for (int m = 0; m < 64; m++) begin
        logic [5:0] ep, rem;
        ep = 6'(p) & 6'(m);
        do_reset();
        pulse(6'(p));
        wr(8'h20, to_reg(6'(m))); #1;
        chk("R5 sweep irq", irq_o, int'(ep != 0));
        if (ep != 0) begin
          chk("R6 sweep vec", vec_o, lowest(ep));
          rem = 6'(p);
          rem[lowest(ep)] = 1'b0;
          ack(); #1;
          chk("R7 sweep irq after ack", irq_o, 0);
          wr(8'h20, 8'hDE); #1;
          chk("R7 sweep remaining irq", irq_o, int'(rem != 0));
          if (rem != 0) chk("R7 sweep remaining vec", vec_o, lowest(rem));
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule